// File: doc/BRIEF.md
# Power-mode clock enable controller

This block derives every internal clock enable of a small processor from one fast input clock. Internal clocks are represented as single-cycle enable pulses in the input-clock domain, so the whole design stays synchronous. A normal internal clock runs at half the input rate. An optional powersave prescaler slows the internal rate further, by a power of two up to 64. Two gating domains sit on top of that rate. The core domain covers the execution and bus units. The peripheral domain keeps running in Idle.

Software-side logic writes a mode request together with a prescaler setting. The controller holds these as pending values and applies them only at a boundary, which is the cycle of an enable pulse, so no shortened period ever appears. Powerdown also drops the oscillator enable. A wake request returns Idle or Powerdown to normal running. When leaving Powerdown, the controller waits a fixed settle time after the oscillator enable rises before any enable pulse is issued.

Top module: `clkpm_ctrl`

## Requirements
- R1: After reset the status `mode_o` reads 0 (running), `ps_on` is 0 and `osc_en` is 1.
- R2: When running with powersave off, `periph_ce` and `core_ce` pulse together, once every 2 input clocks, and `periph_ce` is never high in two consecutive cycles.
- R3: With powersave on and select value s, the pulse period is 2·2^s input clocks for s = 0..6. The reserved value s = 7 gives the same period as s = 6 (128). With powersave off, the select field has no effect.
- R4: In Idle (`mode_o` = 1), `core_ce` stays 0 while `periph_ce` keeps the period set by the prescaler. `core_ce` is never high without `periph_ce`.
- R5: In Powerdown (`mode_o` = 2), `osc_en` is 0 and both enables are 0.
- R6: A wake request sampled in Powerdown raises `osc_en` on the next cycle with `mode_o` = 3 (settling). Both enables stay low for 16 input clocks after that. The block then runs, and its first pulse comes 15 + 2·D cycles after the cycle in which `osc_en` first reads 1, where D is the divide ratio.
- R7: A wake request sampled in Idle returns the block to running (`mode_o` = 0) at the next pulse boundary.
- R8: A written mode or prescaler setting takes effect only at a pulse. The pulse that applies it still ends a full period of the old setting. The next interval is a full period of the new setting, and `ps_on` changes only in the cycle after a pulse or right after settling.
- R9: When a wake request and a write arrive in the same cycle, the write's prescaler fields are kept but the requested mode becomes running, even if the write asked for Idle or Powerdown.
- R10: Mode write codes are 0 = run, 1 = Idle, 2 = Powerdown. The reserved code 3 is treated as run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the mode and prescaler request |
| cfg_mode | input | 2 | Requested mode code (0 run, 1 idle, 2 powerdown, 3 as run) |
| cfg_ps_en | input | 1 | Requested powersave enable |
| cfg_ps_sel | input | 3 | Requested prescaler select, log2 of the divide ratio |
| wake_req | input | 1 | Wake request from Idle or Powerdown |
| core_ce | output | 1 | Enable pulse for the execution and bus units |
| periph_ce | output | 1 | Enable pulse for the peripherals |
| osc_en | output | 1 | Oscillator enable |
| mode_o | output | 2 | Current state: 0 run, 1 idle, 2 powerdown, 3 settling |
| ps_on | output | 1 | Powersave prescaler currently applied |

## Verification
A wake request and a configuration write can arrive in the same input clock. This collision can also land while an earlier request is still waiting for its boundary. The bench drives both strobes together, once with an Idle write and once with a Powerdown write. After the next pulse it judges the outcome by three things: the status must read running, `ps_on` must follow the write, and the interval that follows must match the newly written prescaler. Applying at the boundary can also coincide with a pulse that is still timed by the old setting. That case is judged by measuring the old-period interval that ends in the applying pulse, and then the new one.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_HALT = 2'd2,
        PM_WAKE = 2'd3
    } pm_state_e;

    // Map a written mode code onto a requested state; code 3 is reserved.
    function automatic pm_state_e decode_mode(input logic [1:0] code);
        pm_state_e r;
        case (code)
            2'd1:    r = PM_IDLE;
            2'd2:    r = PM_HALT;
            default: r = PM_RUN;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/clkpm_prescale.sv
module clkpm_prescale #(
    parameter int SEL_W   = 3,
    parameter int MAX_LOG = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ps_en,
    input  logic [SEL_W-1:0] ps_sel,
    output logic             tick
);
    localparam int CNT_W = MAX_LOG;

    typedef struct packed {
        logic             phase;
        logic [CNT_W-1:0] cnt;
    } pre_regs_t;

    pre_regs_t q, d;
    int                 eff;
    logic [CNT_W:0]     span;
    logic [CNT_W-1:0]   limit;
    logic               base;

    always_comb begin
        // Select values above the largest ratio saturate to it.
        eff   = (int'(ps_sel) > MAX_LOG) ? MAX_LOG : int'(ps_sel);
        span  = (CNT_W+1)'(1) << eff;
        limit = CNT_W'(span - (CNT_W+1)'(1));
        base  = run && q.phase;
        tick  = base && (!ps_en || (q.cnt == limit));

        d = q;
        if (!run) begin
            d = '0;
        end else begin
            d.phase = ~q.phase;
            if (base) begin
                d.cnt = tick ? '0 : q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/clkpm_settle.sv
module clkpm_settle #(
    parameter int SETTLE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic done
);
    localparam int SETTLE_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

    logic [SETTLE_W-1:0] cnt_q, cnt_d;

    always_comb begin
        done  = en && (cnt_q == SETTLE_W'(SETTLE_CYC - 1));
        cnt_d = '0;
        if (en && !done) cnt_d = cnt_q + SETTLE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/clkpm_seq.sv
module clkpm_seq
    import clkpm_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_ps_en,
    input  logic [SEL_W-1:0] cfg_ps_sel,
    input  logic             wake_req,
    input  logic             tick,
    input  logic             settle_done,
    output pm_state_e        state,
    output logic             ps_en,
    output logic [SEL_W-1:0] ps_sel
);
    typedef struct packed {
        pm_state_e        state;
        logic             ps_en;
        logic [SEL_W-1:0] ps_sel;
        pm_state_e        pend_mode;
        logic             pend_ps;
        logic [SEL_W-1:0] pend_sel;
    } seq_regs_t;

    seq_regs_t q, d;

    always_comb begin
        d = q;

        // Pending request: a wake overrides the mode of a coincident write.
        if (cfg_wr) begin
            d.pend_mode = decode_mode(cfg_mode);
            d.pend_ps   = cfg_ps_en;
            d.pend_sel  = cfg_ps_sel;
        end
        if (wake_req) d.pend_mode = PM_RUN;

        case (q.state)
            PM_RUN, PM_IDLE: begin
                // Apply only at a pulse, where the derived clock returns low.
                if (tick) begin
                    d.state  = q.pend_mode;
                    d.ps_en  = q.pend_ps;
                    d.ps_sel = q.pend_sel;
                end
            end
            PM_HALT: begin
                if (wake_req) d.state = PM_WAKE;
            end
            PM_WAKE: begin
                if (settle_done) begin
                    d.state  = PM_RUN;
                    d.ps_en  = q.pend_ps;
                    d.ps_sel = q.pend_sel;
                end
            end
            default: d.state = PM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state     <= PM_RUN;
            q.ps_en     <= 1'b0;
            q.ps_sel    <= '0;
            q.pend_mode <= PM_RUN;
            q.pend_ps   <= 1'b0;
            q.pend_sel  <= '0;
        end else begin
            q <= d;
        end
    end

    assign state  = q.state;
    assign ps_en  = q.ps_en;
    assign ps_sel = q.ps_sel;

endmodule

// File: rtl/clkpm_ctrl.sv
module clkpm_ctrl
    import clkpm_pkg::*;
#(
    parameter int SEL_W      = 3,
    parameter int MAX_LOG    = 6,
    parameter int SETTLE_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_ps_en,
    input  logic [SEL_W-1:0] cfg_ps_sel,
    input  logic             wake_req,
    output logic             core_ce,
    output logic             periph_ce,
    output logic             osc_en,
    output logic [1:0]       mode_o,
    output logic             ps_on
);
    pm_state_e        state;
    logic             ps_en;
    logic [SEL_W-1:0] ps_sel;
    logic             tick;
    logic             running;
    logic             settling;
    logic             settle_done;

    assign running  = (state == PM_RUN) || (state == PM_IDLE);
    assign settling = (state == PM_WAKE);

    clkpm_seq #(.SEL_W(SEL_W)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_mode    (cfg_mode),
        .cfg_ps_en   (cfg_ps_en),
        .cfg_ps_sel  (cfg_ps_sel),
        .wake_req    (wake_req),
        .tick        (tick),
        .settle_done (settle_done),
        .state       (state),
        .ps_en       (ps_en),
        .ps_sel      (ps_sel)
    );

    clkpm_prescale #(.SEL_W(SEL_W), .MAX_LOG(MAX_LOG)) pre_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (running),
        .ps_en  (ps_en),
        .ps_sel (ps_sel),
        .tick   (tick)
    );

    clkpm_settle #(.SETTLE_CYC(SETTLE_CYC)) settle_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (settling),
        .done  (settle_done)
    );

    assign periph_ce = tick;
    assign core_ce   = tick && (state == PM_RUN);
    assign osc_en    = (state != PM_HALT);
    assign mode_o    = state;
    assign ps_on     = ps_en;

endmodule

// File: rtl/clkpm_ctrl_chk.sv
module clkpm_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       core_ce,
    input logic       periph_ce,
    input logic       osc_en,
    input logic [1:0] mode_o,
    input logic       ps_on
);
    p_active_core_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0 && periph_ce) |-> core_ce);

    p_half_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ce |=> !periph_ce);

    p_core_needs_periph_r4: assert property (@(posedge clk) disable iff (!rst_n)
        core_ce |-> periph_ce);

    p_idle_core_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1) |-> !core_ce);

    p_halt_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (!periph_ce && !core_ce && mode_o == 2'd2));

    p_settle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd3) |-> (osc_en && !periph_ce));

    p_osc_rise_settles_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en) |-> (mode_o == 2'd3));

    p_ps_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ps_on) |-> ($past(periph_ce) || $past(mode_o) == 2'd3));

endmodule

bind clkpm_ctrl clkpm_ctrl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .core_ce   (core_ce),
    .periph_ce (periph_ce),
    .osc_en    (osc_en),
    .mode_o    (mode_o),
    .ps_on     (ps_on)
);

// File: tb/clkpm_ctrl_tb_top.sv
module clkpm_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic       cfg_ps_en = 1'b0;
    logic [2:0] cfg_ps_sel = 3'd0;
    logic       wake_req = 1'b0;
    logic       core_ce, periph_ce, osc_en, ps_on;
    logic [1:0] mode_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkpm_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
        .cfg_ps_en(cfg_ps_en), .cfg_ps_sel(cfg_ps_sel), .wake_req(wake_req),
        .core_ce(core_ce), .periph_ce(periph_ce), .osc_en(osc_en),
        .mode_o(mode_o), .ps_on(ps_on)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] m, input logic ps, input logic [2:0] sel);
        cfg_wr = 1'b1; cfg_mode = m; cfg_ps_en = ps; cfg_ps_sel = sel;
        step();
        cfg_wr = 1'b0;
    endtask

    task automatic wait_pulse();
        int n = 0;
        while (!periph_ce && n < 1000) begin
            step();
            n++;
        end
        if (!periph_ce) chk(1'b0, "pulse timeout", n, 0);
    endtask

    // From a pulse, step to the next one; counts cycles and core pulses seen.
    task automatic measure(output int n, output int cores);
        n = 0; cores = 0;
        do begin
            step();
            n++;
            if (core_ce) cores++;
        end while (!periph_ce && n < 1000);
    endtask

    function automatic int expect_period(input bit ps, input int sel);
        int lg = (sel > 6) ? 6 : sel;
        return ps ? 2 * (1 << lg) : 2;
    endfunction

    initial begin
        int n, cores;
        repeat (4) step();
        chk(mode_o == 2'd0, "R1 mode after reset", mode_o, 0);
        chk(ps_on == 1'b0,  "R1 ps after reset", ps_on, 0);
        chk(osc_en == 1'b1, "R1 osc after reset", osc_en, 1);
        rst_n = 1'b1;

        // R2: base half-rate running
        wait_pulse();
        chk(core_ce == 1'b1, "R2 core with periph", core_ce, 1);
        measure(n, cores);
        chk(n == 2, "R2 base period", n, 2);
        chk(cores == 1, "R2 core pulse count", cores, 1);

        // R3/R8: sweep the prescaler, including reserved select 7
        for (int s = 0; s < 8; s++) begin
            wr(2'd0, 1'b1, 3'(s));
            wait_pulse();
            step();
            chk(ps_on == 1'b1, "R3 ps applied", ps_on, 1);
            wait_pulse();
            measure(n, cores);
            chk(n == expect_period(1'b1, s), "R3 prescaled period", n, expect_period(1'b1, s));
            chk(cores == 1, "R3 core follows", cores, 1);
        end

        // R8: switch from /64 to /1 right after a pulse: old full period first
        wait_pulse();
        wr(2'd0, 1'b1, 3'd0);
        n = 1;
        while (!periph_ce && n < 1000) begin step(); n++; end
        chk(n == 128, "R8 old period kept", n, 128);
        measure(n, cores);
        chk(n == 2, "R8 new period at once", n, 2);

        // R3: select ignored while powersave off
        wr(2'd0, 1'b0, 3'd5);
        wait_pulse(); step();
        chk(ps_on == 1'b0, "R3 ps off", ps_on, 0);
        wait_pulse();
        measure(n, cores);
        chk(n == 2, "R3 select ignored", n, 2);

        // R4: idle combined with /4
        wr(2'd1, 1'b1, 3'd2);
        wait_pulse(); step();
        chk(mode_o == 2'd1, "R4 idle status", mode_o, 1);
        wait_pulse();
        for (int k = 0; k < 3; k++) begin
            measure(n, cores);
            chk(n == 8, "R4 idle periph period", n, 8);
            chk(cores == 0, "R4 idle core gated", cores, 0);
        end

        // R7: wake from idle mid-interval
        step();
        wake_req = 1'b1; step(); wake_req = 1'b0;
        wait_pulse();
        chk(core_ce == 1'b0, "R7 boundary still idle", core_ce, 0);
        step();
        chk(mode_o == 2'd0, "R7 back to run", mode_o, 0);
        wait_pulse();
        measure(n, cores);
        chk(n == 8 && cores == 1, "R7 core resumes", cores, 1);

        // R5/R6: powerdown and wake, powersave off then /2
        for (int p = 0; p < 2; p++) begin
            wr(2'd2, 1'(p), 3'(p));
            wait_pulse(); step();
            chk(osc_en == 1'b0, "R5 osc off", osc_en, 0);
            chk(mode_o == 2'd2, "R5 halt status", mode_o, 2);
            cores = 0;
            for (int k = 0; k < 40; k++) begin
                step();
                if (periph_ce || core_ce || osc_en) cores++;
            end
            chk(cores == 0, "R5 all quiet", cores, 0);
            wake_req = 1'b1; step(); wake_req = 1'b0;
            chk(osc_en == 1'b1, "R6 osc rises", osc_en, 1);
            chk(mode_o == 2'd3, "R6 settling status", mode_o, 3);
            n = 0;
            while (!periph_ce && n < 1000) begin step(); n++; end
            chk(n == 15 + 2 * (p + 1), "R6 first pulse after settle", n, 15 + 2 * (p + 1));
            chk(mode_o == 2'd0 && core_ce, "R6 running after settle", mode_o, 0);
        end

        // R10: reserved mode code behaves as run
        wr(2'd1, 1'b0, 3'd0);
        wait_pulse(); step();
        chk(mode_o == 2'd1, "R10 idle entered", mode_o, 1);
        wr(2'd3, 1'b0, 3'd0);
        wait_pulse(); step();
        chk(mode_o == 2'd0, "R10 code 3 runs", mode_o, 0);
        wait_pulse();
        measure(n, cores);
        chk(n == 2 && cores == 1, "R10 core pulses", n, 2);

        // R9: wake and write in the same cycle (idle, then powerdown request)
        for (int v = 1; v < 3; v++) begin
            cfg_wr = 1'b1; cfg_mode = 2'(v); cfg_ps_en = 1'b1; cfg_ps_sel = 3'(v);
            wake_req = 1'b1;
            step();
            cfg_wr = 1'b0; wake_req = 1'b0;
            wait_pulse(); step();
            chk(mode_o == 2'd0, "R9 wake wins mode", mode_o, 0);
            chk(ps_on == 1'b1 && osc_en, "R9 write ps kept", ps_on, 1);
            wait_pulse();
            measure(n, cores);
            chk(n == expect_period(1'b1, v), "R9 new period", n, expect_period(1'b1, v));
            chk(cores == 1, "R9 core running", cores, 1);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule